// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block takes a PCIe root port out of power-down with a fixed, timed series of steps. The steps are, in order: start the reference PLL, cycle the PHY and core resets around a long endpoint hold, enable link training, issue three configuration writes, and release the endpoint. After a final settling wait it samples one link-present status bit and reports whether the downstream module answered. Every wait is a whole number of milliseconds. A millisecond is `TICKS_PER_MS` clock cycles, so a simulation can shrink the whole sequence by lowering that one parameter.

A single-cycle `start` launches the sequence from reset or from the finished state. The controller walks these states in order:

- `ST_IDLE`: after reset.
- `ST_PLL_ARM`: divider 1, bypass and power-down on, 10 ms.
- `ST_PLL_PWRUP`: power-down off, 1 ms.
- `ST_PLL_LOCK`: bypass off, 1 ms.
- `ST_PHY_HOLD`: PHY reset on, 10 ms.
- `ST_CORE_HOLD`: core reset on, 10 ms.
- `ST_EP_HOLD`: endpoint held, 100 ms.
- `ST_PHY_FREE`: PHY reset off, 10 ms.
- `ST_CORE_FREE`: core reset off, 10 ms.
- `ST_LINK_EN`: link training on, 1 cycle.
- `ST_WR_CMD`, `ST_WR_BASE`, `ST_WR_LIMIT`: one configuration write each.
- `ST_EP_FREE`: endpoint released, 100 ms.
- `ST_PROBE`: status sampled, 1 cycle.
- `ST_DONE`.

Each timed state leaves on timer expiry. Each single-cycle state leaves on the next clock. `ST_IDLE` and `ST_DONE` leave only on `start`.

Top module: `pcie_rp_bringup`

## Requirements
- R1: After reset: `pll_pwrdn`=1, `pll_bypass`=1 and `pll_refdiv`=0. All of `phy_rst`, `core_rst`, `ep_run`, `ltssm_en`, `cfg_valid`, `cfg_be`, `cfg_errmap`, `done` and `missing` are 0.
- R2: On `start`, the PLL phase runs as follows.
  - First, `pll_refdiv`=1 with `pll_pwrdn`=1 and `pll_bypass`=1 for 10 ms.
  - Next, `pll_pwrdn`=0 with `pll_bypass`=1 for 1 ms.
  - Last, both are 0 for 1 ms.
- R3: `phy_rst` is then raised alone for 10 ms, after which `core_rst` joins it.
- R4: `ep_run` stays 0 (endpoint held) from reset through the release step. With both resets high, the endpoint hold lasts 100 ms, following the 10 ms core-reset wait.
- R5: `phy_rst` falls first and `core_rst` stays high for 10 ms. Then `core_rst` falls and 10 ms pass before link training.
- R6: `ltssm_en` rises with `cfg_be`=0xF and `cfg_errmap`=0x3F, and all three hold until the next `start`.
- R7: Three configuration writes follow in consecutive cycles, each with `cfg_valid`=1 for one cycle:
  - `cfg_addr`=0x004 with the command word (default 0x00000356).
  - `cfg_addr`=0x020 with 0x1FF01000.
  - `cfg_addr`=0x024 with 0x1FF01000.
- R8: `ep_run` then rises (endpoint released) and a 100 ms wait follows.
- R9: In the single cycle after that wait, `link_present` is sampled. `missing` becomes 1 if it was 0 and 0 if it was 1, then holds.
- R10: `done` rises one cycle after the probe and stays high until the next `start`. A `start` while done restarts the sequence and clears `done` and `missing`.
- R11: A `start` that arrives while the sequence is running has no effect on its outputs or timing.
- R12: Every wait of N ms lasts exactly N × `TICKS_PER_MS` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| link_present | input | 1 | Endpoint presence status bit |
| pll_pwrdn | output | 1 | PLL power-down |
| pll_bypass | output | 1 | PLL bypass |
| pll_refdiv | output | REFDIV_W | PLL reference divider |
| phy_rst | output | 1 | PHY reset |
| core_rst | output | 1 | Root port core reset |
| ep_run | output | 1 | Endpoint released (0 holds it in reset) |
| ltssm_en | output | 1 | Link training enable |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_errmap | output | 6 | Slave error response map |
| cfg_valid | output | 1 | Configuration write strobe |
| cfg_addr | output | CFG_AW | Configuration write offset |
| cfg_data | output | CFG_DW | Configuration write data |
| done | output | 1 | Sequence finished |
| missing | output | 1 | Endpoint not detected |

## Verification
The assertions take `start` to be a synchronous input, sampled only at rising edges. They also take `link_present` to be meaningful only in the probe cycle. The stimulus therefore changes `start` only between edges and holds it high for exactly one edge, including the pulses injected mid-run. It sets `link_present` well before each run and leaves it unchanged until `done`. The timing assertion counts cycles against `TICKS_PER_MS`. The bench therefore uses a small tick count so that every wait completes within its window.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    localparam int MS_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLL_ARM,
        ST_PLL_PWRUP,
        ST_PLL_LOCK,
        ST_PHY_HOLD,
        ST_CORE_HOLD,
        ST_EP_HOLD,
        ST_PHY_FREE,
        ST_CORE_FREE,
        ST_LINK_EN,
        ST_WR_CMD,
        ST_WR_BASE,
        ST_WR_LIMIT,
        ST_EP_FREE,
        ST_PROBE,
        ST_DONE
    } rpb_state_e;

    // Milliseconds spent in a state; 0 marks an untimed state.
    function automatic logic [MS_W-1:0] wait_ms(input rpb_state_e s);
        unique case (s)
            ST_PLL_ARM:   wait_ms = MS_W'(10);
            ST_PLL_PWRUP: wait_ms = MS_W'(1);
            ST_PLL_LOCK:  wait_ms = MS_W'(1);
            ST_PHY_HOLD:  wait_ms = MS_W'(10);
            ST_CORE_HOLD: wait_ms = MS_W'(10);
            ST_EP_HOLD:   wait_ms = MS_W'(100);
            ST_PHY_FREE:  wait_ms = MS_W'(10);
            ST_CORE_FREE: wait_ms = MS_W'(10);
            ST_EP_FREE:   wait_ms = MS_W'(100);
            default:      wait_ms = '0;
        endcase
    endfunction

endpackage

// File: rtl/rpb_tick_gen.sv
module rpb_tick_gen #(
    parameter int TICKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0] pre_q;

    assign ms_tick = (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (restart || ms_tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/rpb_ms_timer.sv
module rpb_ms_timer #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [MS_W-1:0] arm_ms,
    input  logic            ms_tick,
    output logic            expired
);
    logic [MS_W-1:0] rem_q;

    assign expired = ms_tick && (rem_q == MS_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (arm)
            rem_q <= arm_ms;
        else if (ms_tick && rem_q != '0)
            rem_q <= rem_q - 1'b1;
    end
endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
    import rpb_pkg::*;
#(
    parameter int TICKS_PER_MS = 100000,
    parameter int REFDIV_W     = 6,
    parameter int CFG_AW       = 12,
    parameter int CFG_DW       = 32,
    parameter logic [CFG_DW-1:0] CMD_WORD    = CFG_DW'('h356),
    parameter logic [CFG_DW-1:0] WINDOW_WORD = CFG_DW'('h1FF01000)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                link_present,
    output logic                pll_pwrdn,
    output logic                pll_bypass,
    output logic [REFDIV_W-1:0] pll_refdiv,
    output logic                phy_rst,
    output logic                core_rst,
    output logic                ep_run,
    output logic                ltssm_en,
    output logic [3:0]          cfg_be,
    output logic [5:0]          cfg_errmap,
    output logic                cfg_valid,
    output logic [CFG_AW-1:0]   cfg_addr,
    output logic [CFG_DW-1:0]   cfg_data,
    output logic                done,
    output logic                missing
);
    localparam logic [CFG_AW-1:0] OFS_CMD   = CFG_AW'('h004);
    localparam logic [CFG_AW-1:0] OFS_BASE  = CFG_AW'('h020);
    localparam logic [CFG_AW-1:0] OFS_LIMIT = CFG_AW'('h024);

    rpb_state_e      state_q, state_d;
    logic            arm, ms_tick, expired, missing_q;
    logic [MS_W-1:0] arm_ms;

    // Timer: a prescaler for milliseconds and a down-counter of them.
    rpb_tick_gen #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(arm), .ms_tick(ms_tick)
    );

    rpb_ms_timer #(.MS_W(MS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_ms(arm_ms),
        .ms_tick(ms_tick), .expired(expired)
    );

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_PLL_ARM;
            ST_PLL_ARM:   if (expired) state_d = ST_PLL_PWRUP;
            ST_PLL_PWRUP: if (expired) state_d = ST_PLL_LOCK;
            ST_PLL_LOCK:  if (expired) state_d = ST_PHY_HOLD;
            ST_PHY_HOLD:  if (expired) state_d = ST_CORE_HOLD;
            ST_CORE_HOLD: if (expired) state_d = ST_EP_HOLD;
            ST_EP_HOLD:   if (expired) state_d = ST_PHY_FREE;
            ST_PHY_FREE:  if (expired) state_d = ST_CORE_FREE;
            ST_CORE_FREE: if (expired) state_d = ST_LINK_EN;
            ST_LINK_EN:   state_d = ST_WR_CMD;
            ST_WR_CMD:    state_d = ST_WR_BASE;
            ST_WR_BASE:   state_d = ST_WR_LIMIT;
            ST_WR_LIMIT:  state_d = ST_EP_FREE;
            ST_EP_FREE:   if (expired) state_d = ST_PROBE;
            ST_PROBE:     state_d = ST_DONE;
        endcase
    end

    assign arm_ms = wait_ms(state_d);
    assign arm    = (state_d != state_q) && (arm_ms != '0);

    // State register and presence flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            missing_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE || state_q == ST_DONE) && start)
                missing_q <= 1'b0;
            else if (state_q == ST_PROBE)
                missing_q <= !link_present;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        pll_pwrdn  = 1'b0;
        pll_bypass = 1'b0;
        pll_refdiv = REFDIV_W'(1);
        phy_rst    = 1'b0;
        core_rst   = 1'b0;
        ep_run     = 1'b0;
        ltssm_en   = 1'b0;
        cfg_valid  = 1'b0;
        cfg_addr   = '0;
        cfg_data   = '0;
        unique case (state_q)
            ST_IDLE: begin
                pll_pwrdn  = 1'b1;
                pll_bypass = 1'b1;
                pll_refdiv = '0;
            end
            ST_PLL_ARM: begin
                pll_pwrdn  = 1'b1;
                pll_bypass = 1'b1;
            end
            ST_PLL_PWRUP: pll_bypass = 1'b1;
            ST_PLL_LOCK, ST_CORE_FREE: ;
            ST_PHY_HOLD: phy_rst = 1'b1;
            ST_CORE_HOLD, ST_EP_HOLD: begin
                phy_rst  = 1'b1;
                core_rst = 1'b1;
            end
            ST_PHY_FREE: core_rst = 1'b1;
            ST_LINK_EN: ltssm_en = 1'b1;
            ST_WR_CMD: begin
                ltssm_en  = 1'b1;
                cfg_valid = 1'b1;
                cfg_addr  = OFS_CMD;
                cfg_data  = CMD_WORD;
            end
            ST_WR_BASE: begin
                ltssm_en  = 1'b1;
                cfg_valid = 1'b1;
                cfg_addr  = OFS_BASE;
                cfg_data  = WINDOW_WORD;
            end
            ST_WR_LIMIT: begin
                ltssm_en  = 1'b1;
                cfg_valid = 1'b1;
                cfg_addr  = OFS_LIMIT;
                cfg_data  = WINDOW_WORD;
            end
            ST_EP_FREE, ST_PROBE, ST_DONE: begin
                ltssm_en = 1'b1;
                ep_run   = 1'b1;
            end
        endcase
    end

    assign cfg_be     = ltssm_en ? 4'hF : 4'h0;
    assign cfg_errmap = ltssm_en ? 6'h3F : 6'h00;
    assign done       = (state_q == ST_DONE);
    assign missing    = missing_q;

endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
    parameter int TICKS_PER_MS = 100000,
    parameter int REFDIV_W     = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                pll_pwrdn,
    input logic                pll_bypass,
    input logic [REFDIV_W-1:0] pll_refdiv,
    input logic                phy_rst,
    input logic                core_rst,
    input logic                ep_run,
    input logic                ltssm_en,
    input logic                cfg_valid,
    input logic                done,
    input logic                missing
);
    logic [31:0] phy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phy_cnt <= '0;
        else if (phy_rst && !core_rst)
            phy_cnt <= phy_cnt + 1'b1;
        else if (!phy_rst)
            phy_cnt <= '0;
    end

    p_bypass_after_pwrdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass) |-> !pll_pwrdn);

    p_core_after_phy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> phy_rst);

    p_cfg_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (ltssm_en && !ep_run && !phy_rst && !core_rst));

    p_ep_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_run) |-> (ltssm_en && !phy_rst && !core_rst));

    p_missing_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(missing));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && pll_refdiv != '0 && !pll_pwrdn && start) |=> !pll_pwrdn);

    p_phy_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> (phy_cnt == 32'(10 * TICKS_PER_MS)));

endmodule

bind pcie_rp_bringup rpb_checker #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .REFDIV_W(REFDIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pll_pwrdn(pll_pwrdn), .pll_bypass(pll_bypass), .pll_refdiv(pll_refdiv),
    .phy_rst(phy_rst), .core_rst(core_rst), .ep_run(ep_run),
    .ltssm_en(ltssm_en), .cfg_valid(cfg_valid), .done(done), .missing(missing)
);

// File: tb/sim_pcie_rp_bringup.sv
`timescale 1ns/1ps
module sim_pcie_rp_bringup;
    localparam int TPM = 3;
    localparam int NPH = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        link_present = 1'b1;
    logic        pll_pwrdn, pll_bypass, phy_rst, core_rst, ep_run, ltssm_en;
    logic        cfg_valid, done, missing;
    logic [5:0]  pll_refdiv;
    logic [3:0]  cfg_be;
    logic [5:0]  cfg_errmap;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pcie_rp_bringup #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .link_present(link_present),
        .pll_pwrdn(pll_pwrdn), .pll_bypass(pll_bypass), .pll_refdiv(pll_refdiv),
        .phy_rst(phy_rst), .core_rst(core_rst), .ep_run(ep_run),
        .ltssm_en(ltssm_en), .cfg_be(cfg_be), .cfg_errmap(cfg_errmap),
        .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .done(done), .missing(missing)
    );

    // Phase table: {pwrdn,bypass,phy,core,ep_run,ltssm,cfg_valid, cycles}
    localparam logic [15:0] PH [NPH] = '{
        {7'b1100000, 9'(10 * TPM)},
        {7'b0100000, 9'(1 * TPM)},
        {7'b0000000, 9'(1 * TPM)},
        {7'b0010000, 9'(10 * TPM)},
        {7'b0011000, 9'(10 * TPM)},
        {7'b0011000, 9'(100 * TPM)},
        {7'b0001000, 9'(10 * TPM)},
        {7'b0000000, 9'(10 * TPM)},
        {7'b0000010, 9'd1},
        {7'b0000011, 9'd1},
        {7'b0000011, 9'd1},
        {7'b0000011, 9'd1},
        {7'b0000110, 9'(100 * TPM)},
        {7'b0000110, 9'd1}
    };
    localparam logic [11:0] EXP_ADDR [3] = '{12'h004, 12'h020, 12'h024};
    localparam logic [31:0] EXP_DATA [3] = '{32'h00000356, 32'h1FF01000, 32'h1FF01000};

    function automatic string req_of(input int p);
        case (p)
            0, 1, 2:   return "R2/R12";
            3, 4:      return "R3/R12";
            5:         return "R4/R12";
            6, 7:      return "R5/R12";
            8:         return "R6";
            9, 10, 11: return "R7";
            default:   return "R8/R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] obs();
        return {pll_pwrdn, pll_bypass, phy_rst, core_rst, ep_run, ltssm_en, cfg_valid};
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // Walk the phase table; optionally inject stray start pulses (R11).
    task automatic run_seq(input bit inject, input bit exp_missing);
        pulse_start();
        for (int p = 0; p < NPH; p++) begin
            bit          ok = 1'b1;
            logic [6:0]  bad_v = '0;
            string       tag = inject ? {req_of(p), "/R11"} : req_of(p);
            for (int c = 0; c < int'(PH[p][8:0]); c++) begin
                @(negedge clk);
                if (obs() != PH[p][15:9] && ok) begin
                    ok = 1'b0;
                    bad_v = obs();
                end
                if (p == 0 && c == 0)
                    check(!done && !missing && pll_refdiv == 6'd1, "R10 restart/R2 refdiv",
                          {26'd0, done, missing, pll_refdiv[3:0]}, 32'h1);
                if (p == 8)
                    check(cfg_be == 4'hF && cfg_errmap == 6'h3F, "R6 be/errmap",
                          {22'd0, cfg_be, cfg_errmap}, {22'd0, 4'hF, 6'h3F});
                if (p >= 9 && p <= 11)
                    check(cfg_addr == EXP_ADDR[p-9] && cfg_data == EXP_DATA[p-9], "R7 write",
                          {cfg_addr[7:0], cfg_data[23:0]},
                          {EXP_ADDR[p-9][7:0], EXP_DATA[p-9][23:0]});
                start = inject && ((p == 1 && c == 1) || (p == 5 && c == 10) ||
                                   (p == 12 && c == 5));
            end
            start = 1'b0;
            check(ok, tag, {25'd0, bad_v}, {25'd0, PH[p][15:9]});
        end
        @(negedge clk);
        check(done == 1'b1, "R10 done", {31'd0, done}, 32'd1);
        check(missing == exp_missing, "R9 missing", {31'd0, missing}, {31'd0, exp_missing});
        check(cfg_be == 4'hF && ltssm_en, "R6 hold", {28'd0, cfg_be}, 32'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pll_pwrdn && pll_bypass && pll_refdiv == 0, "R1 pll",
              {29'd0, pll_pwrdn, pll_bypass, |pll_refdiv}, 32'h6);
        check(obs() == 7'b1100000 && !done && !missing, "R1 ctrl",
              {23'd0, obs(), done, missing}, {23'd0, 7'b1100000, 2'b00});
        check(cfg_be == 0 && cfg_errmap == 0 && cfg_addr == 0 && cfg_data == 0, "R1 cfg",
              {22'd0, cfg_be, cfg_errmap}, 32'd0);

        link_present = 1'b1;
        run_seq(1'b0, 1'b0);

        // R10: done holds while start is low
        begin
            bit held = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!done || missing) held = 1'b0;
            end
            check(held, "R10 hold", {31'd0, held}, 32'd1);
        end

        link_present = 1'b0;
        run_seq(1'b1, 1'b1);

        repeat (5) @(negedge clk);
        check(missing && done, "R9 missing held", {30'd0, missing, done}, 32'd3);

        link_present = 1'b1;
        run_seq(1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule